// File: doc/BRIEF.md
# Fan Tachometer Period Counter

This block measures how fast two cooling fans turn. It times the rotation period, not the pulse rate. A slow reference tick (nominally 22.5 kHz, supplied as a one-cycle enable) passes through a per-fan prescaler into a shared 8-bit saturating counter. The counter runs for exactly two tachometer periods, which is the span from one rising edge to the next-but-one rising edge. A larger count means a slower fan. A count of 255 stands for a fan that has stopped or is too slow to measure. One engine serves both fans, measuring first one and then the other. Each finished count replaces the previous reading for that fan and is announced by a one-cycle update strobe.

Each fan has its own underspeed alarm. In count mode the alarm is raised when the stored count is greater than that fan's limit. In level mode the fan is not measured, and the alarm simply follows the synchronized tach level, with a polarity chosen by the low bit of that fan's divisor code. Measurement runs only while the monitoring enable is high. The register bank that drives the configuration inputs is expected to reset each divisor code to 1 (divide by 2) and each limit to 0xFF.

Top module: `fan_period_monitor`

## Requirements
- R1: Once a count-mode fan is selected, its first synchronized rising edge clears the counter. Each prescaled tick then adds one. The measurement ends on the second rising edge after the start, and the stored count equals the number of reference ticks in that window divided by the divisor, rounded down.
- R2: Each fan's 2-bit divisor code (bits [2i+1:2i] of `div_code`) selects the prescaler ratio: 0 divides by 1, 1 by 2, 2 by 4, 3 by 8.
- R3: The counter saturates at 255. The measurement ends and 255 is stored as soon as full scale is reached, whether or not the closing edge has arrived. A selected fan that shows no rising edge at all also records 255 after 255 prescaled ticks.
- R4: Fans are measured one at a time in index order, starting with fan 0 after the enable rises. Edges on a fan that is not selected are ignored. At most one update strobe is high in any cycle.
- R5: In count mode, `alarm[i]` is 1 exactly when the stored count of fan i is greater than `count_limit[8i+7:8i]`. A count equal to the limit raises no alarm.
- R6: In level mode (`level_mode[i]`=1), fan i is skipped by the measuring engine and its count holds. `alarm[i]` follows the synchronized tach level. When `div_code[2i]` is 1 the alarm is active while the input is low, and when it is 0 the alarm is active while the input is high.
- R7: While `mon_en` is 0 no update occurs and the counts hold. Deasserting it aborts a measurement in progress without storing anything, and measurement restarts from fan 0 when it rises again.
- R8: After reset, every count is 0 and no alarm or strobe is active.
- R9: A stored count changes only in a cycle in which that fan's strobe is high. The strobe lasts one cycle and is raised once per completed measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mon_en | input | 1 | Monitoring enable; 0 stops and aborts measurement |
| ref_tick | input | 1 | One-cycle reference tick enable |
| tach_in | input | 2 | Asynchronous tach inputs, one per fan |
| div_code | input | 4 | Per-fan divisor codes, 2 bits each |
| level_mode | input | 2 | Per-fan mode: 0 count, 1 level |
| count_limit | input | 16 | Per-fan count limits, 8 bits each |
| count_out | output | 16 | Per-fan stored counts, 8 bits each |
| count_upd | output | 2 | Per-fan one-cycle update strobe |
| alarm | output | 2 | Per-fan alarm flags |

## Verification
The bench targets the window boundaries. A design that kept counting past the second closing edge, or failed to clear the ticks that arrive before the first edge, would store a wrong count. It exercises saturation both inside the window and with no edge at all. A counter that wrapped would report a small count, and an engine that waited forever on a dead fan would never strobe. It drives edges on the fan that is not selected and drops the enable in mid-measurement, which exposes designs that measure both fans at once or store a partial count. It also probes the alarm at count equal to the limit and checks both level-mode polarities.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
    typedef enum logic [0:0] {
        ST_ARM   = 1'b0,
        ST_COUNT = 1'b1
    } meter_st_e;
endpackage

// File: rtl/tach_sync.sv
module tach_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic tach_i,
    output logic level_o,
    output logic rise_o
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d    = sync_q;
        sync_d.s1 = tach_i;
        sync_d.s2 = sync_q.s1;
        sync_d.s3 = sync_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign level_o = sync_q.s2;
    assign rise_o  = sync_q.s2 & ~sync_q.s3;
endmodule

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
    parameter int DIV_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             tick_i,
    input  logic [DIV_W-1:0] code_i,
    output logic             tick_o
);
    localparam int PC_W = (1 << DIV_W) - 1;

    logic [PC_W-1:0] pc_d, pc_q;
    logic [PC_W-1:0] lim;

    always_comb begin
        for (int k = 0; k < PC_W; k++) begin
            lim[k] = (k < int'(code_i));
        end
        tick_o = tick_i && (pc_q >= lim);
        pc_d   = pc_q;
        if (clr_i)       pc_d = '0;
        else if (tick_o) pc_d = '0;
        else if (tick_i) pc_d = pc_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_d;
    end
endmodule

// File: rtl/period_meter.sv
module period_meter
    import fpm_pkg::*;
#(
    parameter int N_FANS = 2,
    parameter int CNT_W  = 8,
    parameter int SEL_W  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mon_en_i,
    input  logic [N_FANS-1:0] rise_i,
    input  logic [N_FANS-1:0] skip_i,
    input  logic              ptick_i,
    output logic [SEL_W-1:0]  sel_o,
    output logic              presc_clr_o,
    output logic              done_o,
    output logic [CNT_W-1:0]  res_o,
    output logic [SEL_W-1:0]  res_sel_o
);
    localparam logic [CNT_W-1:0] FULL = '1;

    typedef struct packed {
        meter_st_e        st;
        logic [SEL_W-1:0] sel;
        logic [CNT_W-1:0] cnt;
        logic             edge1;
        logic             done;
        logic [CNT_W-1:0] res;
        logic [SEL_W-1:0] rsel;
    } meter_t;

    meter_t m_d, m_q;
    logic [CNT_W-1:0] cnt_inc;
    logic [SEL_W-1:0] sel_nxt;
    logic             clr;

    always_comb begin
        m_d     = m_q;
        m_d.done = 1'b0;
        clr     = 1'b0;
        cnt_inc = (ptick_i && m_q.cnt != FULL) ? m_q.cnt + 1'b1 : m_q.cnt;
        sel_nxt = (int'(m_q.sel) == N_FANS - 1) ? '0 : m_q.sel + 1'b1;
        if (!mon_en_i) begin
            m_d.st    = ST_ARM;
            m_d.sel   = '0;
            m_d.cnt   = '0;
            m_d.edge1 = 1'b0;
            clr       = 1'b1;
        end else begin
            case (m_q.st)
                ST_ARM: begin
                    if (skip_i[m_q.sel]) begin
                        m_d.sel = sel_nxt;
                        m_d.cnt = '0;
                        clr     = 1'b1;
                    end else if (rise_i[m_q.sel]) begin
                        m_d.st    = ST_COUNT;
                        m_d.cnt   = '0;
                        m_d.edge1 = 1'b0;
                        clr       = 1'b1;
                    end else if (cnt_inc == FULL) begin
                        m_d.done = 1'b1;
                        m_d.res  = FULL;
                        m_d.rsel = m_q.sel;
                        m_d.sel  = sel_nxt;
                        m_d.cnt  = '0;
                        clr      = 1'b1;
                    end else begin
                        m_d.cnt = cnt_inc;
                    end
                end
                default: begin
                    if ((rise_i[m_q.sel] && m_q.edge1) || cnt_inc == FULL) begin
                        m_d.done  = 1'b1;
                        m_d.res   = cnt_inc;
                        m_d.rsel  = m_q.sel;
                        m_d.sel   = sel_nxt;
                        m_d.st    = ST_ARM;
                        m_d.cnt   = '0;
                        m_d.edge1 = 1'b0;
                        clr       = 1'b1;
                    end else begin
                        m_d.cnt = cnt_inc;
                        if (rise_i[m_q.sel]) m_d.edge1 = 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_q <= '{st: ST_ARM, default: '0};
        else        m_q <= m_d;
    end

    assign sel_o       = m_q.sel;
    assign presc_clr_o = clr;
    assign done_o      = m_q.done;
    assign res_o       = m_q.res;
    assign res_sel_o   = m_q.rsel;

    generate
        if (N_FANS > 1) begin : g_adv
            // R4
            seq_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
                m_q.done |-> (m_q.rsel != m_q.sel || skip_i != '0));
        end
    endgenerate
endmodule

// File: rtl/fan_period_monitor.sv
module fan_period_monitor #(
    parameter int N_FANS = 2,
    parameter int CNT_W  = 8,
    parameter int DIV_W  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    mon_en,
    input  logic                    ref_tick,
    input  logic [N_FANS-1:0]       tach_in,
    input  logic [N_FANS*DIV_W-1:0] div_code,
    input  logic [N_FANS-1:0]       level_mode,
    input  logic [N_FANS*CNT_W-1:0] count_limit,
    output logic [N_FANS*CNT_W-1:0] count_out,
    output logic [N_FANS-1:0]       count_upd,
    output logic [N_FANS-1:0]       alarm
);
    localparam int SEL_W = (N_FANS > 1) ? $clog2(N_FANS) : 1;

    typedef struct packed {
        logic [N_FANS-1:0][CNT_W-1:0] cnt;
        logic [N_FANS-1:0]            upd;
        logic [N_FANS-1:0]            alm;
    } out_t;

    out_t o_d, o_q;

    logic [N_FANS-1:0] lvl, rise;
    logic [SEL_W-1:0]  sel, res_sel;
    logic [DIV_W-1:0]  sel_code;
    logic              ptick, presc_clr, done;
    logic [CNT_W-1:0]  res;

    generate
        for (genvar g = 0; g < N_FANS; g++) begin : g_sync
            tach_sync u_sync (
                .clk    (clk),
                .rst_n  (rst_n),
                .tach_i (tach_in[g]),
                .level_o(lvl[g]),
                .rise_o (rise[g])
            );
        end
    endgenerate

    always_comb sel_code = div_code[int'(sel)*DIV_W +: DIV_W];

    tick_prescaler #(.DIV_W(DIV_W)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (presc_clr),
        .tick_i(ref_tick),
        .code_i(sel_code),
        .tick_o(ptick)
    );

    period_meter #(.N_FANS(N_FANS), .CNT_W(CNT_W), .SEL_W(SEL_W)) u_meter (
        .clk        (clk),
        .rst_n      (rst_n),
        .mon_en_i   (mon_en),
        .rise_i     (rise),
        .skip_i     (level_mode),
        .ptick_i    (ptick),
        .sel_o      (sel),
        .presc_clr_o(presc_clr),
        .done_o     (done),
        .res_o      (res),
        .res_sel_o  (res_sel)
    );

    always_comb begin
        o_d     = o_q;
        o_d.upd = '0;
        for (int i = 0; i < N_FANS; i++) begin
            if (done && int'(res_sel) == i) begin
                o_d.cnt[i] = res;
                o_d.upd[i] = 1'b1;
            end
            if (level_mode[i])
                o_d.alm[i] = div_code[i*DIV_W] ? ~lvl[i] : lvl[i];
            else
                o_d.alm[i] = o_d.cnt[i] > count_limit[i*CNT_W +: CNT_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign count_out = o_q.cnt;
    assign count_upd = o_q.upd;
    assign alarm     = o_q.alm;

    // R4
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(count_upd));

    // R7
    abort_no_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mon_en |-> ##2 (count_upd == '0));

    generate
        for (genvar g = 0; g < N_FANS; g++) begin : g_chk
            // R9
            hold_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !count_upd[g] |-> $stable(count_out[g*CNT_W +: CNT_W]));
            // R5
            cmp_alarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (!level_mode[g] && !$past(level_mode[g])) |->
                (alarm[g] == (count_out[g*CNT_W +: CNT_W] >
                              $past(count_limit[g*CNT_W +: CNT_W]))));
        end
    endgenerate
endmodule

// File: tb/tb_fan_period_monitor.sv
module tb_fan_period_monitor;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mon_en = 1'b0;
    logic        ref_tick = 1'b0;
    logic [1:0]  tach_in = '0;
    logic [3:0]  div_code = 4'b0001;
    logic [1:0]  level_mode = '0;
    logic [15:0] count_limit = 16'hFFFF;
    logic [15:0] count_out;
    logic [1:0]  count_upd;
    logic [1:0]  alarm;

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;
    bit       seen [2];
    int       cap  [2];
    int       hits [2];
    int       wide = 0;
    int       multi = 0;
    logic [1:0] upd_prev = '0;

    fan_period_monitor dut (
        .clk(clk), .rst_n(rst_n), .mon_en(mon_en), .ref_tick(ref_tick),
        .tach_in(tach_in), .div_code(div_code), .level_mode(level_mode),
        .count_limit(count_limit), .count_out(count_out),
        .count_upd(count_upd), .alarm(alarm)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        #1;
        if (count_upd[0] && count_upd[1]) multi++;
        for (int i = 0; i < 2; i++) begin
            if (count_upd[i]) begin
                seen[i] = 1'b1;
                cap[i]  = int'(count_out[i*8 +: 8]);
                hits[i]++;
                if (upd_prev[i]) wide++;
            end
        end
        upd_prev = count_upd;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        repeat (n) begin
            @(negedge clk) ref_tick = 1'b1;
            @(negedge clk) ref_tick = 1'b0;
        end
    endtask

    task automatic clr_seen();
        seen[0] = 0; seen[1] = 0;
    endtask

    task automatic set_tach(input int f, input logic v);
        @(negedge clk) tach_in[f] = v;
    endtask

    // three rising edges, n1 ticks in first period, n2 in second
    task automatic measure(input int f, input int n1, input int n2, input int exp, input string req);
        int h0;
        h0 = hits[f];
        clr_seen();
        set_tach(f, 1); cyc(4); ticks(n1);
        set_tach(f, 0); cyc(2);
        set_tach(f, 1); cyc(4); ticks(n2);
        set_tach(f, 0); cyc(2);
        set_tach(f, 1); cyc(6);
        chk({req, " strobe"}, int'(seen[f]), 1);
        chk({req, " count"}, cap[f], exp);
        chk({req, " one strobe R9"}, hits[f] - h0, 1);
        set_tach(f, 0); cyc(4);
    endtask

    task automatic restart();
        @(negedge clk) mon_en = 1'b0; cyc(3);
        @(negedge clk) mon_en = 1'b1; cyc(2);
    endtask

    task automatic t_reset();
        chk("R8 count0", int'(count_out[7:0]), 0);
        chk("R8 count1", int'(count_out[15:8]), 0);
        chk("R8 alarm", int'(alarm), 0);
        chk("R8 strobe", int'(count_upd), 0);
    endtask

    task automatic t_idle();
        // R7: no measurement while disabled
        clr_seen();
        set_tach(0, 1); cyc(4); ticks(5); set_tach(0, 0); cyc(2);
        set_tach(0, 1); cyc(4); ticks(5); set_tach(0, 0); cyc(2);
        set_tach(0, 1); cyc(6); set_tach(0, 0); cyc(4);
        chk("R7 disabled no strobe", int'(seen[0]), 0);
    endtask

    task automatic t_divisors();
        level_mode = 2'b10;
        restart();
        div_code = 4'b0001;
        measure(0, 30, 31, 30, "R1 div2");
        div_code = 4'b0000;
        measure(0, 40, 41, 81, "R2 div1");
        div_code = 4'b0010;
        measure(0, 40, 41, 20, "R2 div4");
        div_code = 4'b0011;
        measure(0, 40, 41, 10, "R2 div8");
    endtask

    task automatic t_saturate();
        div_code = 4'b0000;
        // stopped fan: no edge
        clr_seen();
        ticks(254); cyc(4);
        chk("R3 stopped 254 no strobe", int'(seen[0]), 0);
        ticks(1); cyc(4);
        chk("R3 stopped strobe", int'(seen[0]), 1);
        chk("R3 stopped count", cap[0], 255);
        cyc(4);
        // saturation inside window
        clr_seen();
        set_tach(0, 1); cyc(4); ticks(254); cyc(4);
        chk("R3 window 254 no strobe", int'(seen[0]), 0);
        ticks(1); cyc(4);
        chk("R3 window full strobe", int'(seen[0]), 1);
        chk("R3 window full count", cap[0], 255);
        set_tach(0, 0); cyc(4);
    endtask

    task automatic t_alternate();
        level_mode = 2'b00;
        div_code = 4'b1001;
        restart();
        clr_seen();
        set_tach(1, 1); cyc(4); ticks(20); set_tach(1, 0); cyc(2);
        set_tach(1, 1); cyc(4); set_tach(1, 0); cyc(2);
        set_tach(1, 1); cyc(6); set_tach(1, 0); cyc(4);
        chk("R4 unselected fan1 ignored", int'(seen[1]), 0);
        chk("R4 fan1 count holds", int'(count_out[15:8]), 0);
        measure(0, 50, 50, 50, "R4 fan0 first");
        chk("R4 fan1 not yet", int'(seen[1]), 0);
        measure(1, 50, 50, 25, "R4 fan1 second");
        chk("R4 fan0 untouched", int'(count_out[7:0]), 50);
        chk("R4 single strobe per cycle", multi, 0);
    endtask

    task automatic t_alarm();
        @(negedge clk) count_limit = {8'hFF, 8'd49}; cyc(3);
        chk("R5 count above limit", int'(alarm[0]), 1);
        @(negedge clk) count_limit = {8'hFF, 8'd50}; cyc(3);
        chk("R5 count equal limit", int'(alarm[0]), 0);
        @(negedge clk) count_limit = {8'd24, 8'hFF}; cyc(3);
        chk("R5 fan1 above limit", int'(alarm[1]), 1);
        chk("R5 fan0 at FF", int'(alarm[0]), 0);
        @(negedge clk) count_limit = 16'hFFFF; cyc(3);
    endtask

    task automatic t_level();
        int h0;
        h0 = hits[0];
        level_mode = 2'b01;
        div_code = 4'b0001;
        cyc(5);
        chk("R6 low-active, input low", int'(alarm[0]), 1);
        set_tach(0, 1); cyc(5);
        chk("R6 low-active, input high", int'(alarm[0]), 0);
        @(negedge clk) div_code = 4'b0000; cyc(3);
        chk("R6 high-active, input high", int'(alarm[0]), 1);
        set_tach(0, 0); cyc(5);
        chk("R6 high-active, input low", int'(alarm[0]), 0);
        set_tach(0, 1); cyc(3); set_tach(0, 0); cyc(3);
        set_tach(0, 1); cyc(3); set_tach(0, 0); cyc(5);
        chk("R6 level fan no strobe", hits[0] - h0, 0);
        chk("R6 level fan count holds", int'(count_out[7:0]), 50);
    endtask

    task automatic t_abort();
        level_mode = 2'b10;
        div_code = 4'b0000;
        restart();
        clr_seen();
        set_tach(0, 1); cyc(4); ticks(10); set_tach(0, 0); cyc(2);
        set_tach(0, 1); cyc(4); ticks(10);
        @(negedge clk) mon_en = 1'b0;
        set_tach(0, 0); cyc(2);
        set_tach(0, 1); cyc(6);
        chk("R7 abort no strobe", int'(seen[0]), 0);
        chk("R7 abort count holds", int'(count_out[7:0]), 50);
        set_tach(0, 0); cyc(4);
        @(negedge clk) mon_en = 1'b1; cyc(2);
        measure(0, 20, 20, 40, "R7 restart");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        hits[0] = 0; hits[1] = 0; cap[0] = 0; cap[1] = 0;
        clr_seen();
        cyc(3);
        t_reset();
        @(negedge clk) rst_n = 1'b1;
        cyc(2);
        t_reset();
        t_idle();
        @(negedge clk) mon_en = 1'b1;
        t_divisors();
        t_saturate();
        t_alternate();
        t_alarm();
        t_level();
        t_abort();
        chk("R9 strobe one cycle wide", wide, 0);
        done_flag = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule